// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt output for a processor. Each line can be set to edge or level sensitivity. The controller keeps a pending-request set, a mask and an in-service set. It picks the winning request by fixed, fully nested priority, where line 0 ranks highest. On a one-cycle acknowledge strobe it returns an 8-bit vector.

Software reaches the controller through two byte addresses: a command port (address 0) and an auxiliary port (address 1). Setup is a short sequence of initialization writes that loads the vector base and a cascade configuration byte. After setup, software writes the mask through the auxiliary port. It sends end-of-interrupt and read-select commands through the command port. Trigger modes sit in a separate register with their own write strobe and readback.

Top module: `picTop`

## Requirements
- R1: After reset the interrupt output is low, command-port reads return 0x00 (pending set), auxiliary-port reads return the mask 0xFF, the trigger register reads 0x00 and the cascade byte output is 0x00.
- R2: A command-port write with bit 4 set starts initialization, and its bit 0 states whether a final mode byte follows. The next auxiliary writes are taken in turn as the vector base, the cascade byte, and then the mode byte if one was requested. None of them changes the mask. Auxiliary writes after the sequence load the mask.
- R3: When the acknowledge strobe finds a granted request on line n, the vector output in that same cycle is base + n and in-service bit n is set from the next cycle.
- R4: The mask is read back on the auxiliary port. A mask bit of 1 keeps its line from raising the interrupt output, and a mask bit of 0 lets it through.
- R5: Among several unmasked pending lines, the lowest-numbered one wins.
- R6: A pending line raises the interrupt output only if its number is lower than that of every line in service.
- R7: A command-port write of 0x20 clears the lowest-numbered in-service bit. Any other command-port write with bits 4 and 3 both clear leaves the in-service set unchanged.
- R8: A command-port write with bit 4 clear and bit 3 set selects what the command port reads: low bits 2'b11 select the in-service set and 2'b10 select the pending set. Starting initialization clears the in-service set and selects the pending set again.
- R9: If the acknowledge strobe arrives while no request is granted, the vector is base + 7 and the in-service set is unchanged.
- R10: The trigger register is written by its own strobe and reads back its value. Bit n = 0 makes line n edge-sensitive and bit n = 1 makes it level-sensitive.
- R11: In edge mode a rising edge latches the pending bit, which stays set after the line falls until that line is acknowledged. A line held high after its acknowledge does not request again.
- R12: In level mode the pending bit follows the line directly, both on the command-port readback and on the interrupt output.
- R13: The cascade byte from initialization is only stored, and it is presented on the cascade byte output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 1 | 0 = command port, 1 = auxiliary port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed port |
| trigWr | input | 1 | Trigger-mode register write strobe |
| trigWdata | input | 8 | Trigger-mode write data |
| trigRdata | output | 8 | Trigger-mode readback |
| irqIn | input | 8 | Interrupt request lines |
| intAck | input | 1 | One-cycle acknowledge strobe |
| intOut | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector, valid in the acknowledge cycle |
| cascCfg | output | 8 | Stored cascade configuration byte |

## Verification
The hardest case to reach is the spurious acknowledge. A level-mode line must raise the interrupt output and then drop before the acknowledge cycle. The stimulus switches one line to level mode, drives it high, checks that the output rises, releases the line and only then issues the strobe. Both the base + 7 vector and an unchanged in-service readback are expected. Nesting is exercised in the same way, with a low-priority request arriving while a higher line is in service and a higher one arriving afterwards.

// File: rtl/picPkg.sv
package picPkg;
  localparam int IRQ_N    = 8;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = $clog2(IRQ_N);
  localparam int INIT_BIT = 4;
  localparam int SEL_BIT  = 3;
  localparam int MODE_BIT = 0;
  localparam logic [BYTE_W-1:0] EOI_CODE = 8'h20;

  typedef enum logic [1:0] {
    INIT_IDLE,
    INIT_BASE,
    INIT_CASC,
    INIT_MODE
  } initStateT;

  typedef struct packed {
    logic initStart;
    logic loadBase;
    logic loadCasc;
    logic loadMask;
    logic eoi;
    logic selIsr;
    logic selPend;
  } picStrobeT;

  // {any, index of lowest set bit}
  function automatic logic [IDX_W:0] findLow(input logic [IRQ_N-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/picCtrl.sv
module picCtrl
  import picPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output picStrobeT         strobes
);
  initStateT stateQ, stateD;
  logic      needModeQ, needModeD;
  logic      cmdWr, auxWr;

  always_comb begin
    cmdWr = busWr & ~busAddr;
    auxWr = busWr & busAddr;

    strobes.initStart = cmdWr & busWdata[INIT_BIT];
    strobes.eoi       = cmdWr & (busWdata == EOI_CODE);
    strobes.selIsr    = cmdWr & ~busWdata[INIT_BIT] & busWdata[SEL_BIT]
                        & (busWdata[1:0] == 2'b11);
    strobes.selPend   = cmdWr & ~busWdata[INIT_BIT] & busWdata[SEL_BIT]
                        & (busWdata[1:0] == 2'b10);
    strobes.loadBase  = auxWr & (stateQ == INIT_BASE);
    strobes.loadCasc  = auxWr & (stateQ == INIT_CASC);
    strobes.loadMask  = auxWr & (stateQ == INIT_IDLE);

    stateD    = stateQ;
    needModeD = needModeQ;
    if (strobes.initStart) begin
      stateD    = INIT_BASE;
      needModeD = busWdata[MODE_BIT];
    end else if (auxWr) begin
      unique case (stateQ)
        INIT_BASE: stateD = INIT_CASC;
        INIT_CASC: stateD = needModeQ ? INIT_MODE : INIT_IDLE;
        INIT_MODE: stateD = INIT_IDLE;
        default:   stateD = INIT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= INIT_IDLE;
      needModeQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      needModeQ <= needModeD;
    end
  end
endmodule

// File: rtl/picReqCell.sv
module picReqCell (
  input  logic clk,
  input  logic rstN,
  input  logic irqBit,
  input  logic levelMode,
  input  logic ackClr,
  output logic pendBit
);
  logic prevQ, latchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= 1'b0;
      latchQ <= 1'b0;
    end else begin
      prevQ  <= irqBit;
      latchQ <= ((latchQ & ~ackClr) | (irqBit & ~prevQ)) & ~levelMode;
    end
  end

  assign pendBit = levelMode ? irqBit : latchQ;
endmodule

// File: rtl/picDatapath.sv
module picDatapath
  import picPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  picStrobeT         strobes,
  input  logic              busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              trigWr,
  input  logic [IRQ_N-1:0]  trigWdata,
  output logic [IRQ_N-1:0]  trigRdata,
  input  logic [IRQ_N-1:0]  irqIn,
  input  logic              intAck,
  output logic              intOut,
  output logic [BYTE_W-1:0] vecOut,
  output logic [BYTE_W-1:0] cascCfg,
  output logic [IRQ_N-1:0]  pendQ,
  output logic [IRQ_N-1:0]  isrQ,
  output logic [IRQ_N-1:0]  maskQ,
  output logic [BYTE_W-1:0] baseQ
);
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(IRQ_N - 1);

  logic [IRQ_N-1:0]  maskR, isrR, elcrR, pend, cand, ackClr, eoiClr;
  logic [BYTE_W-1:0] baseR, cascR;
  logic              selIsrR, grant;
  logic [IDX_W:0]    winLow, isrLow;
  logic [IDX_W-1:0]  winIdx, isrIdx, vecIdx;

  for (genvar g = 0; g < IRQ_N; g++) begin : gReq
    picReqCell uCell (
      .clk      (clk),
      .rstN     (rstN),
      .irqBit   (irqIn[g]),
      .levelMode(elcrR[g]),
      .ackClr   (ackClr[g]),
      .pendBit  (pend[g])
    );
  end

  always_comb begin
    cand   = pend & ~maskR;
    winLow = findLow(cand);
    isrLow = findLow(isrR);
    winIdx = winLow[IDX_W-1:0];
    isrIdx = isrLow[IDX_W-1:0];
    grant  = winLow[IDX_W] & (~isrLow[IDX_W] | (winIdx < isrIdx));
    vecIdx = grant ? winIdx : SPUR_IDX;
    ackClr = (intAck & grant) ? (IRQ_N'(1) << winIdx) : '0;
    eoiClr = (strobes.eoi & isrLow[IDX_W]) ? (IRQ_N'(1) << isrIdx) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskR   <= '1;
      isrR    <= '0;
      elcrR   <= '0;
      baseR   <= '0;
      cascR   <= '0;
      selIsrR <= 1'b0;
    end else begin
      if (strobes.initStart) isrR <= '0;
      else                   isrR <= (isrR & ~eoiClr) | ackClr;
      if (strobes.initStart)    selIsrR <= 1'b0;
      else if (strobes.selIsr)  selIsrR <= 1'b1;
      else if (strobes.selPend) selIsrR <= 1'b0;
      if (strobes.loadMask) maskR <= busWdata[IRQ_N-1:0];
      if (strobes.loadBase) baseR <= busWdata;
      if (strobes.loadCasc) cascR <= busWdata;
      if (trigWr)           elcrR <= trigWdata;
    end
  end

  assign intOut    = grant;
  assign vecOut    = baseR + BYTE_W'(vecIdx);
  assign busRdata  = busAddr ? BYTE_W'(maskR) : BYTE_W'(selIsrR ? isrR : pend);
  assign trigRdata = elcrR;
  assign cascCfg   = cascR;
  assign pendQ     = pend;
  assign isrQ      = isrR;
  assign maskQ     = maskR;
  assign baseQ     = baseR;
endmodule

// File: rtl/picTop.sv
module picTop
  import picPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              trigWr,
  input  logic [IRQ_N-1:0]  trigWdata,
  output logic [IRQ_N-1:0]  trigRdata,
  input  logic [IRQ_N-1:0]  irqIn,
  input  logic              intAck,
  output logic              intOut,
  output logic [BYTE_W-1:0] vecOut,
  output logic [BYTE_W-1:0] cascCfg
);
  picStrobeT         strobes;
  logic [IRQ_N-1:0]  pendQ, isrQ, maskQ;
  logic [BYTE_W-1:0] baseQ;

  picCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strobes (strobes)
  );

  picDatapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .trigWr   (trigWr),
    .trigWdata(trigWdata),
    .trigRdata(trigRdata),
    .irqIn    (irqIn),
    .intAck   (intAck),
    .intOut   (intOut),
    .vecOut   (vecOut),
    .cascCfg  (cascCfg),
    .pendQ    (pendQ),
    .isrQ     (isrQ),
    .maskQ    (maskQ),
    .baseQ    (baseQ)
  );
endmodule

// File: rtl/picChecker.sv
module picChecker (
  input logic       clk,
  input logic       rstN,
  input logic       busWr,
  input logic       busAddr,
  input logic [7:0] busWdata,
  input logic       intAck,
  input logic       intOut,
  input logic [7:0] vecOut,
  input logic [7:0] pendQ,
  input logic [7:0] isrQ,
  input logic [7:0] maskQ,
  input logic [7:0] baseQ
);
  logic [7:0] cand, lowBit, vecOff;
  assign cand   = pendQ & ~maskQ;
  assign lowBit = cand & (~cand + 8'd1);
  assign vecOff = vecOut - baseQ;

  // R4: output only with an unmasked pending line
  p_grant_unmasked_r4: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (cand != 8'd0));

  // R6: no in-service bit at or above the winner's rank
  p_nested_r6: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((isrQ & (lowBit | (lowBit - 8'd1))) == 8'd0));

  // R3: acknowledged vector stays inside the eight-entry window
  p_vec_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> (vecOff < 8'd8));

  // R3: a granted acknowledge adds exactly one in-service bit
  p_ack_grows_r3: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intOut && !busWr) |=> ($countones(isrQ) == $countones($past(isrQ)) + 1));

  // R9: spurious vector
  p_spur_vec_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intOut) |-> (vecOff == 8'd7));

  // R9: spurious acknowledge leaves in-service set alone
  p_spur_isr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intOut && !busWr) |=> $stable(isrQ));

  // R7: end-of-interrupt removes exactly one bit
  p_eoi_shrink_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr && busWdata == 8'h20 && !intAck && isrQ != 8'd0)
      |=> ($countones(isrQ) == $countones($past(isrQ)) - 1));
endmodule

bind picTop picChecker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .intAck  (intAck),
  .intOut  (intOut),
  .vecOut  (vecOut),
  .pendQ   (pendQ),
  .isrQ    (isrQ),
  .maskQ   (maskQ),
  .baseQ   (baseQ)
);

// File: tb/tb_picTop.sv
module tb_picTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0, busAddr = 1'b0, trigWr = 1'b0, intAck = 1'b0;
  logic [7:0] busWdata = '0, trigWdata = '0, irqIn = '0;
  logic [7:0] busRdata, trigRdata, vecOut, cascCfg;
  logic       intOut;

  always #10 clk = ~clk;

  picTop dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .trigWr(trigWr),
    .trigWdata(trigWdata), .trigRdata(trigRdata), .irqIn(irqIn),
    .intAck(intAck), .intOut(intOut), .vecOut(vecOut), .cascCfg(cascCfg)
  );

  int nRun = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mMask, mIsr, mLatch, mPrev, mElcr, mBase, mCasc;
  bit mSelIsr, mNeedMode;
  int mStep;

  function automatic logic [7:0] mPend();
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = mElcr[i] ? irqIn[i] : mLatch[i];
    return p;
  endfunction

  function automatic int mWin();
    logic [7:0] c;
    c = mPend() & ~mMask;
    for (int i = 0; i < 8; i++) if (c[i]) return i;
    return -1;
  endfunction

  function automatic bit mGrant();
    int w;
    w = mWin();
    if (w < 0) return 0;
    for (int j = 0; j <= w; j++) if (mIsr[j]) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask = 8'hFF; mIsr = '0; mLatch = '0; mPrev = '0; mElcr = '0;
      mBase = '0; mCasc = '0; mSelIsr = 0; mNeedMode = 0; mStep = 0;
    end else begin
      int w; bit g, done; logic [7:0] nIsr, nLatch;
      w = mWin(); g = mGrant();
      nIsr = mIsr;
      if (busWr && !busAddr && busWdata == 8'h20) begin
        done = 0;
        for (int i = 0; i < 8; i++)
          if (!done && mIsr[i]) begin nIsr[i] = 0; done = 1; end
      end
      if (intAck && g) nIsr[w] = 1;
      for (int i = 0; i < 8; i++) begin
        bit clr, rise;
        clr  = intAck && g && (w == i);
        rise = irqIn[i] && !mPrev[i];
        nLatch[i] = mElcr[i] ? 1'b0 : ((mLatch[i] && !clr) || rise);
      end
      if (busWr && !busAddr) begin
        if (busWdata[4]) begin
          nIsr = '0; mSelIsr = 0; mStep = 1; mNeedMode = busWdata[0];
        end else if (busWdata[3]) begin
          if (busWdata[1:0] == 2'b11) mSelIsr = 1;
          else if (busWdata[1:0] == 2'b10) mSelIsr = 0;
        end
      end
      if (busWr && busAddr) begin
        case (mStep)
          0: mMask = busWdata;
          1: begin mBase = busWdata; mStep = 2; end
          2: begin mCasc = busWdata; mStep = mNeedMode ? 3 : 0; end
          default: mStep = 0;
        endcase
      end
      if (trigWr) mElcr = trigWdata;
      mIsr = nIsr; mLatch = nLatch; mPrev = irqIn;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R5 R6 intOut vs model", int'(intOut), int'(mGrant()));
      chk("R4 R8 busRdata vs model", int'(busRdata),
          int'(busAddr ? mMask : (mSelIsr ? mIsr : mPend())));
      chk("R10 trigRdata vs model", int'(trigRdata), int'(mElcr));
      chk("R13 cascCfg vs model", int'(cascCfg), int'(mCasc));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wrPort(input logic a, input logic [7:0] d);
    @(negedge clk); #1 busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); #1 busWr = 0;
  endtask

  task automatic rdPort(input logic a, output logic [7:0] d);
    @(negedge clk); #1 busAddr = a;
    #2 d = busRdata;
  endtask

  task automatic wrTrig(input logic [7:0] d);
    @(negedge clk); #1 trigWr = 1; trigWdata = d;
    @(negedge clk); #1 trigWr = 0;
  endtask

  task automatic setIrq(input logic [7:0] v);
    @(negedge clk); #1 irqIn = v;
  endtask

  task automatic pulse(input logic [7:0] v);
    setIrq(v);
    setIrq(8'h00);
  endtask

  task automatic doAck(output logic [7:0] vec);
    @(negedge clk); #1 intAck = 1;
    #3 vec = vecOut;
    @(negedge clk); #1 intAck = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, vec;
    tick(3);
    rstN = 1;
    tick(1);

    // R1 reset state
    chk("R1 intOut", int'(intOut), 0);
    rdPort(0, rd); chk("R1 command read", rd, 8'h00);
    rdPort(1, rd); chk("R1 mask read", rd, 8'hFF);
    chk("R1 trigger read", trigRdata, 8'h00);
    chk("R1 cascade", cascCfg, 8'h00);

    // R2 init with mode byte, base 0x40
    wrPort(0, 8'h11); wrPort(1, 8'h40); wrPort(1, 8'h04); wrPort(1, 8'h01);
    rdPort(1, rd); chk("R2 mask untouched by init words", rd, 8'hFF);
    chk("R13 cascade stored", cascCfg, 8'h04);
    wrPort(1, 8'h00);
    rdPort(1, rd); chk("R4 mask written after init", rd, 8'h00);

    // R11 edge latch, R3 vector
    pulse(8'h08); tick(1);
    rdPort(0, rd); chk("R11 edge pending held after fall", rd, 8'h08);
    chk("R3 intOut raised", int'(intOut), 1);
    doAck(vec); chk("R3 vector base+3", vec, 8'h43);
    wrPort(0, 8'h0B);
    rdPort(0, rd); chk("R8 in-service readback", rd, 8'h08);

    // R6 nesting
    pulse(8'h20); tick(1);
    chk("R6 lower priority blocked", int'(intOut), 0);
    pulse(8'h02); tick(1);
    chk("R6 higher priority forwarded", int'(intOut), 1);
    doAck(vec); chk("R6 nested vector", vec, 8'h41);
    rdPort(0, rd); chk("R3 in-service bits 1 and 3", rd, 8'h0A);

    // R7 end of interrupt
    wrPort(0, 8'h20);
    rdPort(0, rd); chk("R7 EOI clears bit 1", rd, 8'h08);
    wrPort(0, 8'h60);
    rdPort(0, rd); chk("R7 other command ignored", rd, 8'h08);
    wrPort(0, 8'h20);
    rdPort(0, rd); chk("R7 EOI clears bit 3", rd, 8'h00);
    chk("R11 latched line 5 now granted", int'(intOut), 1);
    doAck(vec); chk("R11 vector base+5", vec, 8'h45);
    wrPort(0, 8'h20);

    // R5 simultaneous requests
    pulse(8'h44); tick(1);
    doAck(vec); chk("R5 lowest line wins", vec, 8'h42);
    chk("R6 line 6 waits behind line 2", int'(intOut), 0);
    wrPort(0, 8'h20);
    doAck(vec); chk("R5 second winner", vec, 8'h46);
    wrPort(0, 8'h20);

    // R4 masking
    wrPort(1, 8'h10);
    pulse(8'h10); tick(1);
    chk("R4 masked line silent", int'(intOut), 0);
    wrPort(1, 8'h00); tick(1);
    chk("R4 unmasked line raises", int'(intOut), 1);
    doAck(vec); chk("R4 vector base+4", vec, 8'h44);
    wrPort(0, 8'h20);

    // R10 R12 level mode, R9 spurious
    wrTrig(8'h40);
    chk("R10 trigger readback", trigRdata, 8'h40);
    wrPort(0, 8'h0A);
    setIrq(8'h40); tick(1);
    rdPort(0, rd); chk("R12 level pending follows high", rd, 8'h40);
    chk("R12 level raises output", int'(intOut), 1);
    setIrq(8'h00); tick(1);
    rdPort(0, rd); chk("R12 level pending follows low", rd, 8'h00);
    chk("R12 output drops with line", int'(intOut), 0);
    setIrq(8'h40); tick(1);
    chk("R9 request present before vanishing", int'(intOut), 1);
    setIrq(8'h00);
    doAck(vec); chk("R9 spurious vector", vec, 8'h47);
    wrPort(0, 8'h0B);
    rdPort(0, rd); chk("R9 in-service unchanged", rd, 8'h00);
    wrTrig(8'h00);
    chk("R10 trigger back to edge", trigRdata, 8'h00);

    // R2 R8 re-init without mode byte, pending line 7 left latched
    pulse(8'h80); tick(1);
    wrPort(0, 8'h10); wrPort(1, 8'h80); wrPort(1, 8'h22); wrPort(1, 8'h55);
    rdPort(1, rd); chk("R2 third aux write is mask without mode byte", rd, 8'h55);
    chk("R13 new cascade byte", cascCfg, 8'h22);
    rdPort(0, rd); chk("R8 init reselects pending set", rd, 8'h80);
    doAck(vec); chk("R3 vector base+7 real", vec, 8'h87);
    wrPort(0, 8'h0B);
    rdPort(0, rd); chk("R3 real line 7 in service", rd, 8'h80);
    wrPort(0, 8'h20);

    // R11 held-high edge line requests once
    wrPort(1, 8'h00);
    setIrq(8'h01); tick(1);
    doAck(vec); chk("R3 vector base+0", vec, 8'h80);
    wrPort(0, 8'h20); tick(2);
    chk("R11 held line no re-request", int'(intOut), 0);
    setIrq(8'h00); tick(2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule